// File: doc/BRIEF.md
# External memory high-address pin control

This block owns an 8-bit external-memory control register and uses it to decide, pin by pin, whether each of the eight high-address port pins is driven with an address bit or is handed back to the general-purpose port logic. A 3-bit mask field gives pins back from the most significant pin downward. The pins that are kept carry the matching bits of the bus address. The pins that are given back, or every pin while the external memory interface is off, take their value and output enable from the GPIO data and direction inputs. The pins that are given back are no longer driven to the memory. The memory therefore sees the same location at more than one bus address. For example, with the top pin released, addresses 0x8000 and 0x0000 put identical levels on the remaining pins.

The block also decodes when a bus request must go off chip. The lowest 4352 bytes of data space, 0x0000 to 0x10FF, are served internally. Only addresses from 0x1100 upward start an external access.

A second control bit enables a per-line bus keeper on the eight multiplexed address/data pads. This bit works on its own and does not depend on the external memory enable. Each keeper line records the last level seen on its pad, whether the core drove the pad or valid read data came in from outside. While nothing drives the pad, the keeper drives that recorded level back. The strobe timing of the external bus and the memory device are outside this block.

Top module: `xmem_hiaddr_ctl`

## Requirements
- R1: After reset, the control register reads 0x00, every keeper line holds 0, and no keeper output enable is asserted.
- R2: A register write stores bit 7 (keeper enable) and bits 2:0 (high-address mask). A read returns those stored bits with bits 6:3 always 0, so writes to bits 6:3 are ignored.
- R3: While the external memory enable is 0, every high-address pin outputs the GPIO data bit and the GPIO direction bit, whatever the mask holds.
- R4: With the external memory enabled and mask 000, pin i (0..7) drives bus address bit 8+i with its output enable at 1.
- R5: With the external memory enabled and a mask value n from 1 to 6, pins 7 down to 8−n take the GPIO data and direction. The other pins carry address bits with the output enable at 1. Released address bits never reach the pins, so bus addresses that differ only in those bits give identical pin levels.
- R6: With the external memory enabled and mask 111, all eight pins take the GPIO data and direction.
- R7: The external-select output is 1 only when the external memory is enabled, a bus request is present and the bus address is at least 0x1100. Addresses 0x0000 to 0x10FF never select external memory.
- R8: With the keeper enabled, on each clock edge a line records the core's output level while the core output enable is 1, otherwise the incoming level while input data is valid. While neither condition holds, the line asserts its keeper enable and drives the recorded level unchanged.
- R9: The keeper behaves as in R8 regardless of the external memory enable.
- R10: With the keeper bit at 0, no keeper output enable is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register read data |
| xmem_en_i | input | 1 | External memory interface enable |
| bus_req_i | input | 1 | Data-space access request |
| bus_addr_i | input | 16 | Data-space bus address |
| ext_sel_o | output | 1 | Access goes to external memory |
| gpio_out_i | input | 8 | GPIO data for the high-address port |
| gpio_dir_i | input | 8 | GPIO direction for the high-address port |
| hi_do_o | output | 8 | High-address pin drive values |
| hi_oe_o | output | 8 | High-address pin output enables |
| ad_oe_i | input | 1 | Core drives the address/data pads |
| ad_do_i | input | 8 | Core level on the address/data pads |
| ad_di_valid_i | input | 1 | Externally driven pad level is valid |
| ad_di_i | input | 8 | Pad input level |
| ad_keep_o | output | 8 | Keeper-held level per pad |
| ad_keep_oe_o | output | 8 | Keeper drive enable per pad |

## Verification
The bench uses the default parameters: eight high-address pins, a 3-bit mask, eight address/data lines and an internal boundary at 0x1100. With these values all eight mask codes can be reached, both sides of the 0x10FF/0x1100 boundary can be tested, and one GPIO pattern is the exact complement of the address byte, so a single wrong pin shows up in the output. The keeper is tested with the external memory interface held off, which checks that the keeper does not depend on it.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  localparam int unsigned CTRL_W   = 8;
  localparam int unsigned KEEP_BIT = 7;
  localparam int unsigned MASK_W   = 3;

  typedef struct packed {
    logic              keep_en;
    logic [MASK_W-1:0] hi_mask;
  } xmem_ctrl_t;
endpackage

// File: rtl/xmem_ctrl_reg.sv
module xmem_ctrl_reg
  import xmem_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output xmem_ctrl_t        ctrl_o,
  output logic [CTRL_W-1:0] rdata_o
);
  xmem_ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (we_i) begin
      ctrl_q.keep_en <= wdata_i[KEEP_BIT];
      ctrl_q.hi_mask <= wdata_i[MASK_W-1:0];
    end
  end

  // unstored bits read as zero
  always_comb begin
    rdata_o                = '0;
    rdata_o[KEEP_BIT]      = ctrl_q.keep_en;
    rdata_o[MASK_W-1:0]    = ctrl_q.hi_mask;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/xmem_hi_pinmux.sv
module xmem_hi_pinmux #(
  parameter int unsigned HI_W   = 8,
  parameter int unsigned MASK_W = 3
) (
  input  logic              xmem_en_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [HI_W-1:0]   addr_hi_i,
  input  logic [HI_W-1:0]   gpio_out_i,
  input  logic [HI_W-1:0]   gpio_dir_i,
  output logic [HI_W-1:0]   pin_do_o,
  output logic [HI_W-1:0]   pin_oe_o
);
  localparam int unsigned CNT_W = $clog2(HI_W + 1) + MASK_W;
  localparam logic [MASK_W-1:0] MASK_ALL = '1;

  logic [CNT_W-1:0] n_addr;
  logic [HI_W-1:0]  use_addr;

  // number of low pins still carrying address bits
  always_comb begin
    if (mask_i == MASK_ALL || CNT_W'(mask_i) >= CNT_W'(HI_W)) n_addr = '0;
    else n_addr = CNT_W'(HI_W) - CNT_W'(mask_i);
  end

  for (genvar g = 0; g < HI_W; g++) begin : g_pin
    assign use_addr[g] = xmem_en_i && (CNT_W'(g) < n_addr);
    assign pin_do_o[g] = use_addr[g] ? addr_hi_i[g] : gpio_out_i[g];
    assign pin_oe_o[g] = use_addr[g] ? 1'b1         : gpio_dir_i[g];
  end
endmodule

// File: rtl/xmem_ext_decode.sv
module xmem_ext_decode #(
  parameter int unsigned          ADDR_W   = 16,
  parameter logic [ADDR_W-1:0]    EXT_BASE = 16'h1100
) (
  input  logic              xmem_en_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ext_sel_o
);
  assign ext_sel_o = xmem_en_i && req_i && (addr_i >= EXT_BASE);
endmodule

// File: rtl/xmem_bus_keeper.sv
module xmem_bus_keeper #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         keep_en_i,
  input  logic         drv_oe_i,
  input  logic [W-1:0] drv_do_i,
  input  logic         ext_valid_i,
  input  logic [W-1:0] ext_di_i,
  output logic [W-1:0] keep_o,
  output logic [W-1:0] keep_oe_o
);
  logic floating;
  assign floating = !drv_oe_i && !ext_valid_i;

  for (genvar g = 0; g < W; g++) begin : g_line
    logic lvl_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          lvl_q <= 1'b0;
      else if (drv_oe_i)    lvl_q <= drv_do_i[g];
      else if (ext_valid_i) lvl_q <= ext_di_i[g];
    end
    assign keep_o[g]    = lvl_q;
    assign keep_oe_o[g] = keep_en_i && floating;
  end
endmodule

// File: rtl/xmem_hiaddr_ctl.sv
module xmem_hiaddr_ctl
  import xmem_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned HI_W   = 8,
  parameter int unsigned AD_W   = 8,
  parameter logic [ADDR_W-1:0] EXT_BASE = 16'h1100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [CTRL_W-1:0] reg_wdata_i,
  output logic [CTRL_W-1:0] reg_rdata_o,
  input  logic              xmem_en_i,
  input  logic              bus_req_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic              ext_sel_o,
  input  logic [HI_W-1:0]   gpio_out_i,
  input  logic [HI_W-1:0]   gpio_dir_i,
  output logic [HI_W-1:0]   hi_do_o,
  output logic [HI_W-1:0]   hi_oe_o,
  input  logic              ad_oe_i,
  input  logic [AD_W-1:0]   ad_do_i,
  input  logic              ad_di_valid_i,
  input  logic [AD_W-1:0]   ad_di_i,
  output logic [AD_W-1:0]   ad_keep_o,
  output logic [AD_W-1:0]   ad_keep_oe_o
);
  localparam int unsigned HI_LSB = ADDR_W - HI_W;

  xmem_ctrl_t ctrl;

  xmem_ctrl_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .ctrl_o  (ctrl),
    .rdata_o (reg_rdata_o)
  );

  xmem_hi_pinmux #(.HI_W(HI_W), .MASK_W(MASK_W)) u_mux (
    .xmem_en_i  (xmem_en_i),
    .mask_i     (ctrl.hi_mask),
    .addr_hi_i  (bus_addr_i[HI_LSB +: HI_W]),
    .gpio_out_i (gpio_out_i),
    .gpio_dir_i (gpio_dir_i),
    .pin_do_o   (hi_do_o),
    .pin_oe_o   (hi_oe_o)
  );

  xmem_ext_decode #(.ADDR_W(ADDR_W), .EXT_BASE(EXT_BASE)) u_dec (
    .xmem_en_i (xmem_en_i),
    .req_i     (bus_req_i),
    .addr_i    (bus_addr_i),
    .ext_sel_o (ext_sel_o)
  );

  // keeper enable is deliberately not gated by xmem_en_i
  xmem_bus_keeper #(.W(AD_W)) u_keep (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .keep_en_i   (ctrl.keep_en),
    .drv_oe_i    (ad_oe_i),
    .drv_do_i    (ad_do_i),
    .ext_valid_i (ad_di_valid_i),
    .ext_di_i    (ad_di_i),
    .keep_o      (ad_keep_o),
    .keep_oe_o   (ad_keep_oe_o)
  );
endmodule

// File: rtl/xmem_hiaddr_ctl_chk.sv
module xmem_hiaddr_ctl_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned HI_W   = 8,
  parameter int unsigned AD_W   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [7:0]        reg_rdata_o,
  input logic              xmem_en_i,
  input logic              bus_req_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              ext_sel_o,
  input logic [HI_W-1:0]   gpio_out_i,
  input logic [HI_W-1:0]   gpio_dir_i,
  input logic [HI_W-1:0]   hi_do_o,
  input logic [HI_W-1:0]   hi_oe_o,
  input logic              ad_oe_i,
  input logic              ad_di_valid_i,
  input logic [AD_W-1:0]   ad_keep_o,
  input logic [AD_W-1:0]   ad_keep_oe_o
);
  // R2
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[6:3] == 4'h0);

  // R3
  gpio_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xmem_en_i |-> (hi_do_o == gpio_out_i && hi_oe_o == gpio_dir_i));

  // R4
  full_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xmem_en_i && reg_rdata_o[2:0] == 3'd0) |->
      (hi_oe_o == '1 && hi_do_o == bus_addr_i[ADDR_W-1 -: HI_W]));

  // R6
  all_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[2:0] == 3'd7) |-> (hi_do_o == gpio_out_i && hi_oe_o == gpio_dir_i));

  // R7
  internal_region_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i < 16'h1100 || !xmem_en_i || !bus_req_i) |-> !ext_sel_o);

  // R8
  keep_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ad_oe_i && !ad_di_valid_i) |=> $stable(ad_keep_o));

  // R10
  keep_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[7] |-> ad_keep_oe_o == '0);

  // R8
  keep_yield_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ad_oe_i || ad_di_valid_i) |-> ad_keep_oe_o == '0);
endmodule

bind xmem_hiaddr_ctl xmem_hiaddr_ctl_chk u_chk (.*);

// File: tb/xmem_hiaddr_ctl_tb.sv
`timescale 1ns/1ps
module xmem_hiaddr_ctl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        xmem_en_i = 1'b0;
  logic        bus_req_i = 1'b0;
  logic [15:0] bus_addr_i = '0;
  logic        ext_sel_o;
  logic [7:0]  gpio_out_i = 8'h0F;
  logic [7:0]  gpio_dir_i = 8'h55;
  logic [7:0]  hi_do_o, hi_oe_o;
  logic        ad_oe_i = 1'b0;
  logic [7:0]  ad_do_i = '0;
  logic        ad_di_valid_i = 1'b0;
  logic [7:0]  ad_di_i = '0;
  logic [7:0]  ad_keep_o, ad_keep_oe_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  xmem_hiaddr_ctl u_dut (.*);

  // {en, mask, exp_do, exp_oe}; gpio 0F / dir 55 / addr hi F0
  localparam int NV = 10;
  localparam logic [23:0] VEC [NV] = '{
    24'h0_0_0F_55, 24'h0_3_0F_55, 24'h1_0_F0_FF, 24'h1_1_70_7F,
    24'h1_2_30_7F, 24'h1_3_10_5F, 24'h1_4_00_5F, 24'h1_5_08_57,
    24'h1_6_0C_57, 24'h1_7_0F_55
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    bus_addr_i = 16'hF0A5;
    repeat (2) @(negedge clk_i);
    // R1 reset state
    chk("R1 rdata", {8'h0, reg_rdata_o}, 16'h0000);
    chk("R1 keep", {ad_keep_oe_o, ad_keep_o}, 16'h0000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 rdata after release", {8'h0, reg_rdata_o}, 16'h0000);

    // R2 register fields
    wr_reg(8'hFF);
    chk("R2 all ones", {8'h0, reg_rdata_o}, 16'h0087);
    wr_reg(8'h78);
    chk("R2 reserved ignored", {8'h0, reg_rdata_o}, 16'h0000);

    // R3..R6 table
    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      v = VEC[i];
      xmem_en_i = 1'b0;
      wr_reg({5'b0, v[18:16]});
      xmem_en_i = v[20];
      @(negedge clk_i);
      if (!v[20])                 chk("R3 gpio pass", {hi_do_o, hi_oe_o}, v[15:0]);
      else if (v[18:16] == 3'd0)  chk("R4 full address", {hi_do_o, hi_oe_o}, v[15:0]);
      else if (v[18:16] == 3'd7)  chk("R6 all released", {hi_do_o, hi_oe_o}, v[15:0]);
      else                        chk("R5 partial mask", {hi_do_o, hi_oe_o}, v[15:0]);
    end

    // R5 aliasing: top pin released, A15 has no effect on pins
    wr_reg(8'h01);
    xmem_en_i = 1'b1;
    bus_addr_i = 16'h8000;
    @(negedge clk_i);
    chk("R5 alias 8000", {9'h0, hi_do_o[6:0]}, 16'h0000);
    bus_addr_i = 16'h0000;
    @(negedge clk_i);
    chk("R5 alias 0000", {9'h0, hi_do_o[6:0]}, 16'h0000);

    // R7 external select boundary
    bus_req_i = 1'b1;
    bus_addr_i = 16'h10FF;
    @(negedge clk_i);
    chk("R7 10FF internal", {15'h0, ext_sel_o}, 16'h0000);
    bus_addr_i = 16'h1100;
    @(negedge clk_i);
    chk("R7 1100 external", {15'h0, ext_sel_o}, 16'h0001);
    bus_addr_i = 16'hFFFF;
    @(negedge clk_i);
    chk("R7 FFFF external", {15'h0, ext_sel_o}, 16'h0001);
    bus_req_i = 1'b0;
    @(negedge clk_i);
    chk("R7 no request", {15'h0, ext_sel_o}, 16'h0000);
    bus_req_i = 1'b1; xmem_en_i = 1'b0;
    @(negedge clk_i);
    chk("R7 xmem off", {15'h0, ext_sel_o}, 16'h0000);
    bus_req_i = 1'b0;

    // R8/R9 keeper with external memory off
    wr_reg(8'h80);
    ad_oe_i = 1'b1; ad_do_i = 8'hA6;
    @(negedge clk_i);
    chk("R8 core drives, keeper idle", {8'h0, ad_keep_oe_o}, 16'h0000);
    ad_oe_i = 1'b0;
    @(negedge clk_i);
    chk("R9 keeper holds core level", {ad_keep_oe_o, ad_keep_o}, 16'hFFA6);
    @(negedge clk_i);
    chk("R8 hold stable", {ad_keep_oe_o, ad_keep_o}, 16'hFFA6);
    ad_di_valid_i = 1'b1; ad_di_i = 8'h3C;
    @(negedge clk_i);
    chk("R8 input valid, keeper idle", {8'h0, ad_keep_oe_o}, 16'h0000);
    ad_di_valid_i = 1'b0; ad_di_i = 8'hFF;
    @(negedge clk_i);
    chk("R8 holds input level", {ad_keep_oe_o, ad_keep_o}, 16'hFF3C);

    // R10 keeper off
    wr_reg(8'h00);
    chk("R10 keeper disabled", {8'h0, ad_keep_oe_o}, 16'h0000);

    finish_run();
  end
endmodule